// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller with Shortcut Bits

The block gathers 72 level-sensitive interrupt sources into one interrupt request line and one fast-interrupt line. The sources form three banks: a basic bank of 8 and two peripheral banks of 32 each. Each bank has its own enable mask. Software sets bits in the mask through a set register and clears them through a clear register. A source that is pending and enabled is reported in its bank's status word.

The basic status word is the one a handler reads first. It also holds one summary flag for each peripheral bank and eleven shortcut bits. A shortcut bit copies one frequently used peripheral source directly, so the handler can skip reading that bank. When a source has a shortcut, it raises only its shortcut bit and does not raise its bank's summary flag. A separate selector routes any single raw source to the fast-interrupt output. Routing a source there does not take it off the normal request path.

All registers are 32 bits wide at word offsets. Writes take effect at the next clock edge. Reads are combinational.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, all three enable masks and the fast selector read zero (the selector at 0x0C, the masks at 0x10, 0x14 and 0x18), every status word reads zero, and both `irq` and `fiq` are low.
- R2: Writing to 0x10, 0x14 or 0x18 sets the enable bits of peripheral bank 1, peripheral bank 2 or the basic bank where wdata is 1. Writing to 0x1C, 0x20 or 0x24 clears those bits where wdata is 1. Reading 0x10, 0x14 or 0x18 returns the mask, with the basic mask in bits 7:0 and zeros above it.
- R3: The status word at 0x04 (bank 1) and at 0x08 (bank 2) equals the raw inputs ANDed with that bank's mask. Bits 7:0 of the status word at 0x00 equal the basic raw inputs ANDed with the basic mask.
- R4: Bit 8 of the word at 0x00 is 1 when some enabled, active bank 1 source without a shortcut exists. Bit 9 does the same for bank 2. An active source that has a shortcut never sets bit 8 or bit 9.
- R5: Bits 10, 11, 12, 13 and 14 of the word at 0x00 show the enabled status of bank 1 sources 7, 9, 10, 18 and 19. Bits 15 to 20 show bank 2 sources 21, 22, 23, 24, 25 and 30. Bits 31:21 read zero.
- R6: Basic-bank set or clear writes affect only bits 7:0. Bits 8 to 20 of the word at 0x00 cannot be masked from the basic bank's registers.
- R7: `irq` is high exactly when the word at 0x00 is nonzero.
- R8: The selector at 0x0C holds an index in bits 6:0 and an enable flag in bit 7. Indices 0–31 select bank 1, 32–63 select bank 2, 64–71 select the basic bank, and 72–127 select nothing. `fiq` equals the raw level of the selected source while the flag is set, and is 0 otherwise. Bits 31:8 of the selector read zero.
- R9: `fiq` ignores the enable masks. A source that is both selected and enabled drives `fiq` and `irq` high together.
- R10: Writes to 0x00, 0x04 and 0x08 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| src_basic | input | 8 | Basic bank raw levels |
| src_bank1 | input | 32 | Peripheral bank 1 raw levels |
| src_bank2 | input | 32 | Peripheral bank 2 raw levels |
| irq | output | 1 | Interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The hardest situation to reach is a mixed mask state: some shortcut sources are enabled and others are masked while non-shortcut sources are active at the same time. Only this state shows that the summary flags and the shortcut bits are derived separately. The bench walks a single active source across every position of every bank. It then drives a pseudo-random sequence of raw patterns and masks, with the masks built through set and clear writes. Each status word is compared against an arithmetic model that holds the shortcut list. A full sweep over all 128 selector values covers the fast output, including the indices that select nothing.

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int ADDR_W = 6,
  parameter int NBASIC = 8,
  parameter int NPERI  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NBASIC-1:0] src_basic,
  input  logic [NPERI-1:0]  src_bank1,
  input  logic [NPERI-1:0]  src_bank2,
  output logic              irq,
  output logic              fiq
);
  localparam logic [ADDR_W-1:0] A_ST0  = ADDR_W'(6'h00);
  localparam logic [ADDR_W-1:0] A_ST1  = ADDR_W'(6'h04);
  localparam logic [ADDR_W-1:0] A_ST2  = ADDR_W'(6'h08);
  localparam logic [ADDR_W-1:0] A_FSEL = ADDR_W'(6'h0C);
  localparam logic [ADDR_W-1:0] A_SET1 = ADDR_W'(6'h10);
  localparam logic [ADDR_W-1:0] A_SET2 = ADDR_W'(6'h14);
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(6'h18);
  localparam logic [ADDR_W-1:0] A_CLR1 = ADDR_W'(6'h1C);
  localparam logic [ADDR_W-1:0] A_CLR2 = ADDR_W'(6'h20);
  localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(6'h24);
  localparam logic [NPERI-1:0]  SC1 = NPERI'(32'h000C_0680);
  localparam logic [NPERI-1:0]  SC2 = NPERI'(32'h43E0_0000);
  localparam int NALL = 128;

  logic [NBASIC-1:0] en0;
  logic [NPERI-1:0]  en1, en2;
  logic [7:0]        fsel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en0  <= '0;
      en1  <= '0;
      en2  <= '0;
      fsel <= '0;
    end else if (wr_en) begin
      case (addr)
        A_SET0: en0 <= en0 | wdata[NBASIC-1:0];
        A_CLR0: en0 <= en0 & ~wdata[NBASIC-1:0];
        A_SET1: en1 <= en1 | wdata[NPERI-1:0];
        A_CLR1: en1 <= en1 & ~wdata[NPERI-1:0];
        A_SET2: en2 <= en2 | wdata[NPERI-1:0];
        A_CLR2: en2 <= en2 & ~wdata[NPERI-1:0];
        A_FSEL: fsel <= wdata[7:0];
        default: ;
      endcase
    end
  end

  logic [NBASIC-1:0] p0;
  logic [NPERI-1:0]  p1, p2;
  logic [4:0]        short1;
  logic [5:0]        short2;
  logic              sum1, sum2;
  logic [31:0]       st0;

  assign p0 = src_basic & en0;
  assign p1 = src_bank1 & en1;
  assign p2 = src_bank2 & en2;
  assign short1 = {p1[19], p1[18], p1[10], p1[9], p1[7]};
  assign short2 = {p2[30], p2[25], p2[24], p2[23], p2[22], p2[21]};
  assign sum1 = |(p1 & ~SC1);
  assign sum2 = |(p2 & ~SC2);
  assign st0 = 32'({short2, short1, sum2, sum1, p0});

  assign irq = |{p0, p1, p2};

  logic [NALL-1:0] raw_all;
  assign raw_all = NALL'({src_basic, src_bank2, src_bank1});
  assign fiq = fsel[7] & raw_all[fsel[6:0]];

  always_comb begin
    case (addr)
      A_ST0:  rdata = st0;
      A_ST1:  rdata = 32'(p1);
      A_ST2:  rdata = 32'(p2);
      A_FSEL: rdata = {24'b0, fsel};
      A_SET0: rdata = 32'(en0);
      A_SET1: rdata = 32'(en1);
      A_SET2: rdata = 32'(en2);
      default: rdata = '0;
    endcase
  end

  // R2
  set_bank1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET1) |=> ((en1 & $past(wdata[NPERI-1:0])) == $past(wdata[NPERI-1:0])));
  // R2
  clear_bank1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR1) |=> ((en1 & $past(wdata[NPERI-1:0])) == '0));
  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|{en0, en1, en2}));
  // R4
  summary_only_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_bank1 & en1 & ~SC1) == '0) |-> !st0[8]);
  // R8
  fiq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq |-> fsel[7]);
  // R10
  status_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_ST0 || addr == A_ST1 || addr == A_ST2)) |=>
      ($stable(en0) && $stable(en1) && $stable(en2) && $stable(fsel)));
endmodule

// File: tb/banked_irq_ctrl_test.sv
module banked_irq_ctrl_test;
  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [7:0] src_basic = 0;
  logic [31:0] src_bank1 = 0, src_bank2 = 0;
  logic irq, fiq;
  int checks = 0, failures = 0;
  logic [7:0] m0;
  logic [31:0] m1, m2;

  banked_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_basic(src_basic), .src_bank1(src_bank1),
    .src_bank2(src_bank2), .irq(irq), .fiq(fiq));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic int sc1_pos(int i);
    case (i)
      7: return 10; 9: return 11; 10: return 12; 18: return 13; 19: return 14;
      default: return -1;
    endcase
  endfunction

  function automatic int sc2_pos(int i);
    case (i)
      21: return 15; 22: return 16; 23: return 17; 24: return 18; 25: return 19; 30: return 20;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] model0(logic [7:0] p0, logic [31:0] p1, logic [31:0] p2);
    logic [31:0] r;
    r = {24'b0, p0};
    for (int i = 0; i < 32; i++) begin
      if (p1[i]) begin
        if (sc1_pos(i) >= 0) r[sc1_pos(i)] = 1'b1; else r[8] = 1'b1;
      end
      if (p2[i]) begin
        if (sc2_pos(i) >= 0) r[sc2_pos(i)] = 1'b1; else r[9] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic check_status(input string req);
    logic [31:0] d, e0;
    e0 = model0(src_basic & m0, src_bank1 & m1, src_bank2 & m2);
    rd(6'h00, d); chk({req, " st0"}, d, e0);
    rd(6'h04, d); chk({req, " st1"}, d, src_bank1 & m1);
    rd(6'h08, d); chk({req, " st2"}, d, src_bank2 & m2);
    chk({req, " R7 irq"}, {31'b0, irq}, {31'b0, e0 != 0});
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog got=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d, lf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(6'(a * 4), d);
      chk("R1 reg after reset", d, 0);
    end
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 fiq", {31'b0, fiq}, 0);

    // R2 set registers and readback
    wr(6'h10, 32'hFFFF_FFFF); wr(6'h14, 32'hFFFF_FFFF); wr(6'h18, 32'hFFFF_FFFF);
    m0 = 8'hFF; m1 = '1; m2 = '1;
    rd(6'h18, d); chk("R2 basic mask width", d, 32'h0000_00FF);
    rd(6'h10, d); chk("R2 bank1 mask", d, 32'hFFFF_FFFF);

    // R3 R4 R5 one-hot walks
    for (int i = 0; i < 32; i++) begin
      src_bank1 = 32'(1) << i; src_bank2 = 0; src_basic = 0;
      check_status("R3/R4/R5 bank1 walk");
      src_bank1 = 0; src_bank2 = 32'(1) << i;
      check_status("R3/R4/R5 bank2 walk");
    end
    for (int i = 0; i < 8; i++) begin
      src_bank2 = 0; src_basic = 8'(1 << i);
      check_status("R3 basic walk");
    end

    // R2 clear
    wr(6'h1C, 32'hAAAA_AAAA); m1 = 32'h5555_5555;
    rd(6'h10, d); chk("R2 bank1 clear", d, 32'h5555_5555);
    src_bank1 = '1; src_bank2 = '1; src_basic = '1;
    check_status("R4 mixed shortcut mask");

    // R6 basic disable cannot touch summary/shortcut bits
    wr(6'h24, 32'h001F_FF00);
    rd(6'h18, d); chk("R6 basic mask kept", d, 32'h0000_00FF);
    wr(6'h24, 32'hFFFF_FFFF); m0 = 0;
    rd(6'h18, d); chk("R6 basic mask cleared", d, 0);
    check_status("R6 summary survives basic clear");
    wr(6'h18, 32'hFFFF_FF00);
    rd(6'h18, d); chk("R6 basic set upper ignored", d, 0);

    // R10 status writes inert
    wr(6'h00, 32'h0); wr(6'h04, 32'h0); wr(6'h08, 32'hFFFF_FFFF);
    check_status("R10 status write");
    rd(6'h14, d); chk("R10 bank2 mask kept", d, m2);

    // random patterns
    lf = 32'hACE1_2345;
    for (int k = 0; k < 200; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      wr(6'h10, lf); wr(6'h1C, ~lf); m1 = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      wr(6'h14, lf ^ 32'h0F0F_0F0F); wr(6'h20, ~(lf ^ 32'h0F0F_0F0F)); m2 = lf ^ 32'h0F0F_0F0F;
      wr(6'h18, {24'b0, lf[15:8]}); wr(6'h24, {24'b0, ~lf[15:8]}); m0 = lf[15:8];
      src_bank1 = lf * 7; src_bank2 = {lf[15:0], lf[31:16]}; src_basic = lf[23:16];
      if (k % 3 == 0) src_bank1 = src_bank1 & 32'h000C_0680;
      check_status("R3/R4/R5 random");
    end

    // R8 fast selector sweep with masks cleared
    wr(6'h1C, '1); wr(6'h20, '1); wr(6'h24, '1); m0 = 0; m1 = 0; m2 = 0;
    src_bank1 = 32'h1357_9BDF; src_bank2 = 32'hF0E1_D2C3; src_basic = 8'hA5;
    for (int idx = 0; idx < 128; idx++) begin
      logic [127:0] all;
      all = {56'b0, src_basic, src_bank2, src_bank1};
      wr(6'h0C, 32'hFFFF_FF80 | 32'(idx));
      chk("R8 fiq select", {31'b0, fiq}, {31'b0, all[idx]});
      chk("R9 fiq ignores mask irq", {31'b0, irq}, 0);
      wr(6'h0C, 32'(idx));
      chk("R8 fiq flag off", {31'b0, fiq}, 0);
    end
    wr(6'h0C, 32'hFFFF_FF05);
    rd(6'h0C, d); chk("R8 selector readback", d, 32'h0000_0005);

    // R9 both outputs together
    src_bank1 = 32'h20; wr(6'h10, 32'h20); m1 = 32'h20;
    wr(6'h0C, 32'h85);
    chk("R9 fiq", {31'b0, fiq}, 1);
    chk("R9 irq", {31'b0, irq}, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule